// File: doc/BRIEF.md
# Multiprocessor programmable interrupt controller

This block collects a parameterised number of external interrupt request lines and delivers them to a small set of processors. Software programs it through a single 32-bit word-addressed register port. For every source it holds a control word with the vector, priority, trigger mode, polarity and an enable mask, plus a destination word that lists which processors may take the source. For every processor it holds a task-priority threshold, and it offers an acknowledge location and an end-of-service location.

For each processor the controller looks at the sources that are pending, unmasked, not already being serviced and routed to that processor. It picks the one with the highest priority and raises that processor's interrupt line when the priority clears both the processor's threshold and the priority of whatever that processor is already servicing. A read of the acknowledge location returns the winning vector and moves the source into service. When nothing qualifies, the read returns a programmable spurious vector. A write to the end-of-service location retires the highest-priority interrupt in service on that processor. A level source that is still asserted then competes again.

Top module: `mpic_top`

## Requirements
- R1: After reset every source control word reads 0x8000_0000 (masked, all other fields zero), every destination and task priority is 0, the spurious vector is 0 and all cpu_irq outputs are low. Source control word layout: vector [7:0], priority [19:16], trigger mode [22] (1 level, 0 edge), polarity [23] (1 active-high, 0 active-low), activity [30] (read-only), mask [31]. Word addresses: feature 0x00, configuration 0x01, spurious 0x02, source s control 0x40+2s, source s destination 0x41+2s, processor c task priority 0x20+4c, acknowledge 0x21+4c, end of service 0x22+4c.
- R2: The read-only feature word reports the number of sources minus one in [7:0], the number of processors minus one in [12:8] and the version code in [23:16] (0x0002_0107 with the default parameters).
- R3: A level-triggered source is pending while its input is at the active level that the polarity bit selects. If it is still active after end of service, it interrupts again.
- R4: An edge-triggered source latches a pending flag on the edge that the polarity bit selects (rising for 1, falling for 0) and ignores the opposite edge. The flag stays set after the input returns and is cleared when the source is acknowledged.
- R5: A source with its mask bit set is never delivered. Writing the mask bit as 1 discards a latched edge, and an edge that arrives while the source is masked is not latched.
- R6: A source reaches processor n only if bit n of its destination word is set.
- R7: A source interrupts a processor only if its priority is strictly greater than that processor's task priority.
- R8: Among eligible sources the highest priority wins. On equal priority the lowest source index wins.
- R9: Reading acknowledge while cpu_irq is high returns the winning vector in bits [7:0] and puts the source in service for that processor. The line then drops, and the activity bit of the source reads 1 until end of service and 0 afterwards when nothing else is pending.
- R10: While a processor services an interrupt, only a strictly higher priority raises its line again. End of service retires the highest-priority interrupt in service on that processor and leaves lower ones in service.
- R11: Reading acknowledge when the processor's line is low returns the spurious vector from word 0x02 and changes no state.
- R12: Writing 1 to bit 0 of the configuration word sets the mask bit of every source, keeps the other fields and drops the lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_in | input | NSRC | External interrupt request lines, asynchronous |
| reg_addr | input | ADDR_W | Word address of the register access |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe, one cycle per read, with a side effect on acknowledge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid from the clock edge that samples reg_rd |
| cpu_irq | output | NCPU | Interrupt request line to each processor |

## Verification
A change on an input line reaches the source logic through two synchroniser stages, so a level source moves cpu_irq after the second clock edge and an edge source after the third, where the edge is latched. The bench therefore waits four edges after driving a line and samples cpu_irq at the falling edge. A register write takes effect at the edge that samples the strobe, and cpu_irq follows combinationally, so line checks come on the falling edge after the write. Read data is registered at the edge that samples reg_rd. The scoreboard queues the expected word when the read is issued and the monitor pops it at the next falling edge.

// File: rtl/mpic_pkg.sv
package mpic_pkg;
  // source control word fields
  localparam int CW_VEC_LSB   = 0;
  localparam int CW_PRI_LSB   = 16;
  localparam int CW_TRIG_BIT  = 22;
  localparam int CW_POL_BIT   = 23;
  localparam int CW_ACT_BIT   = 30;
  localparam int CW_MASK_BIT  = 31;
  // feature word fields
  localparam int FT_SRC_LSB   = 0;
  localparam int FT_CPU_LSB   = 8;
  localparam int FT_VER_LSB   = 16;
  // configuration word
  localparam int CFG_MASKALL_BIT = 0;
  // word addresses
  localparam int AD_FEATURE  = 'h00;
  localparam int AD_CONFIG   = 'h01;
  localparam int AD_SPUR     = 'h02;
  localparam int AD_CPU_BASE = 'h20;
  localparam int AD_SRC_BASE = 'h40;
  // per-processor offsets (stride 4)
  localparam logic [1:0] CPU_OFS_TPR = 2'd0;
  localparam logic [1:0] CPU_OFS_ACK = 2'd1;
  localparam logic [1:0] CPU_OFS_EOS = 2'd2;
endpackage

// File: rtl/mpic_src.sv
module mpic_src
  import mpic_pkg::*;
#(
  parameter int VEC_W = 8,
  parameter int PRI_W = 4,
  parameter int NCPU  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_in,
  input  logic              cw_we,
  input  logic              dst_we,
  input  logic [31:0]       wdata,
  input  logic              mask_all,
  input  logic              claim,
  input  logic              busy,
  output logic [VEC_W-1:0]  vec,
  output logic [PRI_W-1:0]  pri,
  output logic [NCPU-1:0]   dest,
  output logic              pending,
  output logic [31:0]       cw_rdata
);

  logic             sync1_q, sync2_q, hist_q;
  logic             latch_q, latch_d;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic [PRI_W-1:0] pri_q, pri_d;
  logic             trig_q, trig_d;
  logic             pol_q, pol_d;
  logic             mask_q, mask_d;
  logic [NCPU-1:0]  dest_q, dest_d;
  logic             lvl_act, edge_hit, raw_req;
  logic             unused_src_w;

  assign unused_src_w = ^wdata;

  always_comb begin
    lvl_act  = pol_q ? sync2_q : ~sync2_q;
    edge_hit = pol_q ? (sync2_q & ~hist_q) : (~sync2_q & hist_q);

    vec_d  = vec_q;
    pri_d  = pri_q;
    trig_d = trig_q;
    pol_d  = pol_q;
    mask_d = mask_q;
    if (cw_we) begin
      vec_d  = wdata[CW_VEC_LSB +: VEC_W];
      pri_d  = wdata[CW_PRI_LSB +: PRI_W];
      trig_d = wdata[CW_TRIG_BIT];
      pol_d  = wdata[CW_POL_BIT];
      mask_d = wdata[CW_MASK_BIT];
    end
    if (mask_all) mask_d = 1'b1;

    dest_d = dest_q;
    if (dst_we) dest_d = wdata[NCPU-1:0];

    latch_d = (latch_q & ~claim) | (edge_hit & ~mask_q & ~trig_q);
    if (mask_d || trig_d) latch_d = 1'b0;

    raw_req  = ~mask_q & (trig_q ? lvl_act : latch_q);
    pending  = raw_req & ~busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      hist_q  <= 1'b0;
    end else begin
      sync1_q <= line_in;
      sync2_q <= sync1_q;
      hist_q  <= sync2_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q   <= '0;
      pri_q   <= '0;
      trig_q  <= 1'b0;
      pol_q   <= 1'b0;
      mask_q  <= 1'b1;
      dest_q  <= '0;
      latch_q <= 1'b0;
    end else begin
      if (cw_we || mask_all) begin
        vec_q  <= vec_d;
        pri_q  <= pri_d;
        trig_q <= trig_d;
        pol_q  <= pol_d;
        mask_q <= mask_d;
      end
      if (dst_we) dest_q <= dest_d;
      latch_q <= latch_d;
    end
  end

  always_comb begin
    cw_rdata = '0;
    cw_rdata[CW_VEC_LSB +: VEC_W] = vec_q;
    cw_rdata[CW_PRI_LSB +: PRI_W] = pri_q;
    cw_rdata[CW_TRIG_BIT] = trig_q;
    cw_rdata[CW_POL_BIT]  = pol_q;
    cw_rdata[CW_ACT_BIT]  = raw_req | busy;
    cw_rdata[CW_MASK_BIT] = mask_q;
  end

  assign vec  = vec_q;
  assign pri  = pri_q;
  assign dest = dest_q;

  AST_MASK_DROPS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_we && wdata[CW_MASK_BIT]) |=> !latch_q); // R5

  AST_CLAIM_CLEARS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (claim && !trig_q && !edge_hit) |=> !latch_q); // R4

endmodule

// File: rtl/mpic_cpu.sv
module mpic_cpu #(
  parameter int NSRC  = 8,
  parameter int PRI_W = 4,
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   elig,
  input  logic [NSRC*PRI_W-1:0] pri_flat,
  input  logic              tpr_we,
  input  logic [PRI_W-1:0]  tpr_wdata,
  input  logic              ack,
  input  logic              eos,
  output logic              irq,
  output logic [IDX_W-1:0]  win_idx,
  output logic [PRI_W-1:0]  tpr,
  output logic [NSRC-1:0]   isr
);

  logic [PRI_W-1:0] tpr_q, tpr_d;
  logic [NSRC-1:0]  isr_q, isr_d;
  logic             found, isr_any;
  logic [PRI_W-1:0] best_pri, isr_pri, p;
  logic [IDX_W-1:0] best_idx, isr_idx;

  always_comb begin
    found    = 1'b0;
    best_pri = '0;
    best_idx = '0;
    isr_any  = 1'b0;
    isr_pri  = '0;
    isr_idx  = '0;
    for (int s = 0; s < NSRC; s++) begin
      p = pri_flat[s*PRI_W +: PRI_W];
      if (elig[s] && (!found || p > best_pri)) begin
        found    = 1'b1;
        best_pri = p;
        best_idx = IDX_W'(s);
      end
      if (isr_q[s] && (!isr_any || p > isr_pri)) begin
        isr_any = 1'b1;
        isr_pri = p;
        isr_idx = IDX_W'(s);
      end
    end
    irq = found && (best_pri > tpr_q) && (!isr_any || best_pri > isr_pri);

    tpr_d = tpr_we ? tpr_wdata : tpr_q;

    isr_d = isr_q;
    if (ack && irq)
      isr_d[best_idx] = 1'b1;
    else if (eos && isr_any)
      isr_d[isr_idx] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tpr_q <= '0;
      isr_q <= '0;
    end else begin
      if (tpr_we) tpr_q <= tpr_d;
      if (ack || eos) isr_q <= isr_d;
    end
  end

  assign win_idx = best_idx;
  assign tpr     = tpr_q;
  assign isr     = isr_q;

  AST_ACK_TO_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq) |=> isr_q[$past(best_idx)]); // R9

  AST_EOS_RETIRES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (eos && !ack && (isr_q != '0)) |=> ($countones(isr_q) == $countones($past(isr_q)) - 1)); // R10

endmodule

// File: rtl/mpic_top.sv
module mpic_top
  import mpic_pkg::*;
#(
  parameter int NSRC    = 8,
  parameter int NCPU    = 2,
  parameter int VEC_W   = 8,
  parameter int PRI_W   = 4,
  parameter int ADDR_W  = 8,
  parameter int VERSION = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_in,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [NCPU-1:0]   cpu_irq
);

  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  // source side
  logic [VEC_W-1:0] s_vec  [NSRC];
  logic [PRI_W-1:0] s_pri  [NSRC];
  logic [NCPU-1:0]  s_dest [NSRC];
  logic [31:0]      s_cw   [NSRC];
  logic [NSRC-1:0]  s_pend, s_cw_we, s_dst_we, s_claim, s_busy, s_mask;
  logic [NSRC*PRI_W-1:0] pri_flat;

  // processor side
  logic [NCPU-1:0]  c_irq, c_tpr_we, c_ack, c_eos;
  logic [IDX_W-1:0] c_win [NCPU];
  logic [PRI_W-1:0] c_tpr [NCPU];
  logic [NSRC-1:0]  c_isr [NCPU];
  logic [NSRC-1:0]  c_elig [NCPU];
  logic [NCPU-1:0]  owners [NSRC];

  // decode
  logic [ADDR_W-1:0] src_off, cpu_off;
  logic              src_hit, cpu_hit, mask_all;
  logic [31:0]       spur_q, spur_d, feat, rdata_q, rdata_d;

  always_comb begin
    src_off  = reg_addr - ADDR_W'(AD_SRC_BASE);
    cpu_off  = reg_addr - ADDR_W'(AD_CPU_BASE);
    src_hit  = (reg_addr >= ADDR_W'(AD_SRC_BASE)) && (src_off < ADDR_W'(2*NSRC));
    cpu_hit  = (reg_addr >= ADDR_W'(AD_CPU_BASE)) && (cpu_off < ADDR_W'(4*NCPU));
    mask_all = reg_wr && (reg_addr == ADDR_W'(AD_CONFIG)) && reg_wdata[CFG_MASKALL_BIT];
    for (int s = 0; s < NSRC; s++) begin
      s_cw_we[s]  = reg_wr && src_hit && (src_off[ADDR_W-1:1] == (ADDR_W-1)'(s)) && !src_off[0];
      s_dst_we[s] = reg_wr && src_hit && (src_off[ADDR_W-1:1] == (ADDR_W-1)'(s)) &&  src_off[0];
    end
    for (int c = 0; c < NCPU; c++) begin
      c_tpr_we[c] = reg_wr && cpu_hit && (cpu_off[ADDR_W-1:2] == (ADDR_W-2)'(c)) && (cpu_off[1:0] == CPU_OFS_TPR);
      c_ack[c]    = reg_rd && cpu_hit && (cpu_off[ADDR_W-1:2] == (ADDR_W-2)'(c)) && (cpu_off[1:0] == CPU_OFS_ACK);
      c_eos[c]    = reg_wr && cpu_hit && (cpu_off[ADDR_W-1:2] == (ADDR_W-2)'(c)) && (cpu_off[1:0] == CPU_OFS_EOS);
    end
  end

  // cross connections between sources and processors
  always_comb begin
    for (int s = 0; s < NSRC; s++) begin
      pri_flat[s*PRI_W +: PRI_W] = s_pri[s];
      s_claim[s] = 1'b0;
      s_mask[s]  = s_cw[s][CW_MASK_BIT];
      for (int c = 0; c < NCPU; c++) begin
        c_elig[c][s] = s_pend[s] & s_dest[s][c];
        owners[s][c] = c_isr[c][s];
        if (c_ack[c] && c_irq[c] && (c_win[c] == IDX_W'(s))) s_claim[s] = 1'b1;
      end
      s_busy[s] = |owners[s];
    end
  end

  for (genvar gs = 0; gs < NSRC; gs++) begin : g_src
    mpic_src #(.VEC_W(VEC_W), .PRI_W(PRI_W), .NCPU(NCPU)) u_src (
      .clk      (clk),
      .rst_n    (rst_i),
      .line_in  (irq_in[gs]),
      .cw_we    (s_cw_we[gs]),
      .dst_we   (s_dst_we[gs]),
      .wdata    (reg_wdata),
      .mask_all (mask_all),
      .claim    (s_claim[gs]),
      .busy     (s_busy[gs]),
      .vec      (s_vec[gs]),
      .pri      (s_pri[gs]),
      .dest     (s_dest[gs]),
      .pending  (s_pend[gs]),
      .cw_rdata (s_cw[gs])
    );
    AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_i)
      $onehot0(owners[gs])); // R9
  end

  for (genvar gc = 0; gc < NCPU; gc++) begin : g_cpu
    mpic_cpu #(.NSRC(NSRC), .PRI_W(PRI_W)) u_cpu (
      .clk       (clk),
      .rst_n     (rst_i),
      .elig      (c_elig[gc]),
      .pri_flat  (pri_flat),
      .tpr_we    (c_tpr_we[gc]),
      .tpr_wdata (reg_wdata[PRI_W-1:0]),
      .ack       (c_ack[gc]),
      .eos       (c_eos[gc]),
      .irq       (c_irq[gc]),
      .win_idx   (c_win[gc]),
      .tpr       (c_tpr[gc]),
      .isr       (c_isr[gc])
    );
  end

  // global registers and read path
  always_comb begin
    feat = '0;
    feat[FT_SRC_LSB +: 8] = 8'(NSRC - 1);
    feat[FT_CPU_LSB +: 5] = 5'(NCPU - 1);
    feat[FT_VER_LSB +: 8] = 8'(VERSION);

    spur_d = spur_q;
    if (reg_wr && reg_addr == ADDR_W'(AD_SPUR)) begin
      spur_d = '0;
      spur_d[VEC_W-1:0] = reg_wdata[VEC_W-1:0];
    end

    rdata_d = '0;
    if (reg_addr == ADDR_W'(AD_FEATURE)) rdata_d = feat;
    else if (reg_addr == ADDR_W'(AD_SPUR)) rdata_d = spur_q;
    for (int s = 0; s < NSRC; s++) begin
      if (s_cw_we[s] || (reg_rd && src_hit && src_off[ADDR_W-1:1] == (ADDR_W-1)'(s) && !src_off[0]))
        rdata_d = s_cw[s];
      if (reg_rd && src_hit && src_off[ADDR_W-1:1] == (ADDR_W-1)'(s) && src_off[0])
        rdata_d = 32'(s_dest[s]);
    end
    for (int c = 0; c < NCPU; c++) begin
      if (reg_rd && cpu_hit && cpu_off[ADDR_W-1:2] == (ADDR_W-2)'(c) && cpu_off[1:0] == CPU_OFS_TPR)
        rdata_d = 32'(c_tpr[c]);
      if (c_ack[c])
        rdata_d = c_irq[c] ? 32'(s_vec[c_win[c]]) : spur_q;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      spur_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (reg_wr) spur_q  <= spur_d;
      if (reg_rd) rdata_q <= rdata_d;
    end
  end

  assign reg_rdata = rdata_q;
  assign cpu_irq   = c_irq;

  AST_ONE_CLAIM: assert property (@(posedge clk) disable iff (!rst_i)
    $onehot0(s_claim)); // R8

  AST_MASKALL_WRITE: assert property (@(posedge clk) disable iff (!rst_i)
    mask_all |=> (&s_mask)); // R12

  AST_MASKALL_QUIET: assert property (@(posedge clk) disable iff (!rst_i)
    mask_all |=> (cpu_irq == '0)); // R12

endmodule

// File: tb/tb_mpic_top.sv
module tb_mpic_top;
  localparam int NSRC = 8, NCPU = 2, AW = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] irq_in = '0;
  logic [AW-1:0]   reg_addr = '0;
  logic            reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic [NCPU-1:0] cpu_irq;

  int n_checks = 0, n_errors = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  always #5 clk = ~clk;

  mpic_top dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .cpu_irq(cpu_irq)
  );

  function automatic logic [31:0] cw(input int v, input int p, input int trig,
                                     input int pol, input int mask);
    return 32'(v) | (32'(p) << 16) | (32'(trig) << 22) | (32'(pol) << 23) | (32'(mask) << 31);
  endfunction
  localparam logic [31:0] ACT = 32'h4000_0000;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_addr = AW'(a); reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  // driver: issue read and push the expected word
  task automatic rd(input int a, input logic [31:0] e, input string tag);
    @(posedge clk); #1;
    reg_addr = AW'(a); reg_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic chk_irq(input logic [NCPU-1:0] e, input string tag);
    @(negedge clk);
    n_checks++;
    if (cpu_irq !== e) begin
      n_errors++;
      $display("FAIL %s: cpu_irq=%b expected %b", tag, cpu_irq, e);
    end
  endtask

  // monitor
  always @(posedge clk) rd_seen <= reg_rd;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_checks++;
      if (reg_rdata !== e) begin
        n_errors++;
        $display("FAIL %s: rdata=%h expected %h", t, reg_rdata, e);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: run did not complete, got timeout expected completion");
    finish_run();
  end

  initial begin
    irq_in = '0;
    irq_in[2] = 1'b1;
    tick(5);
    rst_n = 1'b1;
    tick(6);

    // reset state
    chk_irq(2'b00, "R1 lines low after reset");
    rd('h00, 32'h0002_0107, "R2 feature word");
    rd('h40, 32'h8000_0000, "R1 source 0 control after reset");
    rd('h21, 32'h0, "R11 ack with reset spurious");
    wr('h02, 32'hFF);
    rd('h21, 32'hFF, "R11 ack returns programmed spurious");

    // level, active high, source 1
    wr('h43, 32'h1);
    wr('h42, cw('h21, 5, 1, 1, 0));
    irq_in[1] = 1'b1; tick(4);
    chk_irq(2'b01, "R3 level source raises cpu0");
    rd('h42, cw('h21, 5, 1, 1, 0) | ACT, "R9 activity while pending");
    rd('h21, 32'h21, "R9 ack vector");
    chk_irq(2'b00, "R9 line drops after ack");
    wr('h22, 0);
    chk_irq(2'b01, "R3 level re-asserts after end of service");
    rd('h21, 32'h21, "R3 second ack");
    irq_in[1] = 1'b0; tick(4);
    wr('h22, 0);
    chk_irq(2'b00, "R3 inactive level stays quiet");
    rd('h42, cw('h21, 5, 1, 1, 0), "R9 activity clear after service");

    // task priority
    wr('h20, 5);
    irq_in[1] = 1'b1; tick(4);
    chk_irq(2'b00, "R7 equal priority blocked");
    rd('h21, 32'hFF, "R11 spurious when blocked");
    wr('h20, 4);
    chk_irq(2'b01, "R7 priority above threshold delivered");
    wr('h42, cw('h21, 5, 1, 1, 1));
    chk_irq(2'b00, "R5 masked source not delivered");
    irq_in[1] = 1'b0;
    wr('h20, 0);

    // edge, active low, source 2
    wr('h45, 32'h1);
    wr('h44, cw('h32, 3, 0, 0, 0));
    irq_in[2] = 1'b0; tick(4);
    chk_irq(2'b01, "R4 falling edge latched");
    irq_in[2] = 1'b1; tick(4);
    chk_irq(2'b01, "R4 latch holds after input returns");
    rd('h21, 32'h32, "R4 edge ack vector");
    chk_irq(2'b00, "R4 line low after ack");
    wr('h22, 0);
    chk_irq(2'b00, "R4 edge consumed by ack");
    wr('h44, cw('h32, 3, 0, 0, 1));
    irq_in[2] = 1'b0; tick(4);
    wr('h44, cw('h32, 3, 0, 0, 0));
    chk_irq(2'b00, "R5 edge while masked not latched");
    irq_in[2] = 1'b1; tick(4);
    chk_irq(2'b00, "R4 opposite edge ignored");
    wr('h44, cw('h32, 3, 0, 0, 1));

    // arbitration: 3 and 4 at 7, 5 at 6
    wr('h47, 1); wr('h46, cw('h43, 7, 1, 1, 0));
    wr('h49, 1); wr('h48, cw('h44, 7, 1, 1, 0));
    wr('h4B, 1); wr('h4A, cw('h45, 6, 1, 1, 0));
    irq_in[5:3] = 3'b111; tick(4);
    rd('h21, 32'h43, "R8 tie goes to lowest index");
    irq_in[3] = 1'b0; tick(4);
    chk_irq(2'b00, "R10 equal and lower blocked while in service");
    wr('h22, 0);
    chk_irq(2'b01, "R10 delivery resumes after end of service");
    rd('h21, 32'h44, "R8 next at priority 7");
    irq_in[4] = 1'b0; tick(4);
    wr('h22, 0);
    rd('h21, 32'h45, "R8 lower priority last");
    wr('h22, 0);

    // nesting: source 5 at 6 in service, source 6 at 9
    wr('h4D, 1); wr('h4C, cw('h66, 9, 1, 1, 0));
    rd('h21, 32'h45, "R10 low priority taken first");
    irq_in[6] = 1'b1; tick(4);
    chk_irq(2'b01, "R10 higher priority nests");
    rd('h21, 32'h66, "R10 nested vector");
    irq_in[6] = 1'b0; tick(4);
    wr('h22, 0);
    chk_irq(2'b00, "R10 lower one still in service");
    rd('h4A, cw('h45, 6, 1, 1, 0) | ACT, "R10 source 5 remains in service");
    rd('h4C, cw('h66, 9, 1, 1, 0), "R10 source 6 retired first");
    wr('h22, 0);
    chk_irq(2'b01, "R3 source 5 level returns");
    rd('h21, 32'h45, "R3 source 5 again");
    irq_in[5] = 1'b0; tick(4);
    wr('h22, 0);

    // destination: source 7 to cpu1
    wr('h4F, 32'h2); wr('h4E, cw('h77, 2, 1, 1, 0));
    irq_in[7] = 1'b1; tick(4);
    chk_irq(2'b10, "R6 routed to cpu1 only");
    rd('h21, 32'hFF, "R6 cpu0 sees spurious");
    rd('h25, 32'h77, "R6 cpu1 ack vector");
    irq_in[7] = 1'b0; tick(4);
    wr('h26, 0);

    // global mask-all
    wr('h42, cw('h21, 5, 1, 1, 0));
    irq_in[1] = 1'b1; tick(4);
    chk_irq(2'b01, "R12 source live before mask-all");
    wr('h01, 32'h1);
    chk_irq(2'b00, "R12 lines drop after mask-all");
    rd('h42, cw('h21, 5, 1, 1, 1), "R12 fields kept, mask set");
    rd('h4E, cw('h77, 2, 1, 1, 1), "R12 other source masked");

    tick(3);
    finish_run();
  end
endmodule